// File: doc/BRIEF.md
# Keyword-Tagged Configuration Autoloader

After reset this block fetches a configuration image from non-volatile memory, one 32-bit word at a time. It issues word reads through a simple request/response port and returns a 48-bit station address once the walk is complete. A static select input picks the memory source, and each source has its own fixed start offset. The image is a run of two-word records. The first word of a record is a tag that carries a marker byte and a 16-bit target register offset. The second word is the value for that target.

Only two targets matter: the low and the high dword of the station address. Records for any other target are read and then discarded. The walk stops when any of three things happens: a tag position holds a word without the marker, a read returns an error, or a maximum word count is reached. When the walk stops, `done` rises and stays high. The station address is built from the two captured dwords. `addr_valid` then reports whether the address can be used as a unicast address.

Top module: `cfgld_autoloader`

## Requirements
- R1: During reset and in the first cycle after it, `done`, `addr_valid`, `rd_req` and `station_addr` are all zero. The first read address is 0x100 when `src_flash`=0 and 0x1F000 when `src_flash`=1.
- R2: Each read address is the previous read address plus 4. Bits 1:0 of every read address are 0. `rd_addr` holds steady while `rd_req` is high and no `rd_ack` has arrived.
- R3: A word read at a tag position is a tag when bits 7:0 equal 0x5A. Bits 15:8 are ignored, and bits 31:16 name the target offset. The next word is always taken as that target's value, even if its low byte is 0x5A. After the value word, a tag is expected again.
- R4: A value word for target `STA_OFS` (default 0x0140) loads the low dword. A value word for `STA_OFS`+4 loads the high dword. Value words for any other target leave `station_addr` unchanged. A later record overwrites an earlier one.
- R5: A word at a tag position whose bits 7:0 differ from 0x5A ends the walk. `done` is high in the cycle after that response, and no further read is issued.
- R6: A response with `rd_err`=1 ends the walk in the same way, whatever the word's position. Its data is not loaded.
- R7: After `MAX_WORDS` (default 64) responses without any other stop condition, the walk ends with `done`=1.
- R8: `station_addr[47:32]` = high dword bits 15:0 and `station_addr[31:0]` = low dword. Address byte 0 is `station_addr[47:40]`, which is high-dword bits 15:8. High-dword bits 31:16 are ignored.
- R9: `addr_valid` is 1 only when `done`=1, `station_addr` is nonzero and `station_addr[40]` (bit 0 of byte 0, the group bit) is 0.
- R10: Once `done` is 1 it stays 1, and `rd_req` stays 0 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_flash | input | 1 | Source select; chooses the start offset; held stable from reset onward |
| rd_req | output | 1 | A word read is outstanding |
| rd_addr | output | ADDR_W | Byte address of the outstanding read |
| rd_ack | input | 1 | One-cycle response strobe for the outstanding read |
| rd_data | input | 32 | Word returned with `rd_ack` |
| rd_err | input | 1 | Read failure, qualified by `rd_ack` |
| station_addr | output | 48 | Assembled station address, byte 0 in bits 47:40 |
| done | output | 1 | Walk finished |
| addr_valid | output | 1 | Station address is a usable unicast address |

## Verification
The assertions assume that the reader raises `rd_ack` only while `rd_req` is high, for one cycle per request, and that `src_flash` does not change after reset. The bench's memory model respects both: it answers only at falling edges when a request is pending, and it drops the strobe at the next falling edge. The bench changes the select only while reset is held. Response latency varies from zero to three cycles, so the address-hold rule is exercised while a request waits.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

  typedef enum logic [1:0] {
    WK_LOAD = 2'd0,
    WK_READ = 2'd1,
    WK_DONE = 2'd2
  } walk_st_t;

  localparam logic [7:0] TAG_MARK = 8'h5A;

  function automatic logic is_tag(input logic [31:0] w);
    return w[7:0] == TAG_MARK;
  endfunction

  function automatic logic [15:0] tag_target(input logic [31:0] w);
    return w[31:16];
  endfunction

  // byte k of the address sits at bits [47-8k -: 8]
  function automatic logic [47:0] pack_station(input logic [31:0] lo_w,
                                               input logic [31:0] hi_w);
    logic [7:0] b [6];
    b[0] = hi_w[15:8];
    b[1] = hi_w[7:0];
    b[2] = lo_w[31:24];
    b[3] = lo_w[23:16];
    b[4] = lo_w[15:8];
    b[5] = lo_w[7:0];
    return {b[0], b[1], b[2], b[3], b[4], b[5]};
  endfunction

  function automatic logic unicast_ok(input logic [47:0] a);
    return (a != 48'd0) && !a[40];
  endfunction

endpackage

// File: rtl/cfgld_walker.sv
module cfgld_walker
  import cfgld_pkg::*;
#(
  parameter int          ADDR_W    = 20,
  parameter logic [31:0] BASE_EE   = 32'h0000_0100,
  parameter logic [31:0] BASE_FL   = 32'h0001_F000,
  parameter int          MAX_WORDS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_flash,
  input  logic              rd_ack,
  input  logic              stop_req,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              word_fire,
  output logic              done
);

  localparam int CNT_W = $clog2(MAX_WORDS + 1);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(3);
  localparam logic [ADDR_W-1:0] START_EE = ADDR_W'(BASE_EE) & ALIGN_MASK;
  localparam logic [ADDR_W-1:0] START_FL = ADDR_W'(BASE_FL) & ALIGN_MASK;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  walk_st_t          st;
  logic [CNT_W-1:0]  cnt;
  logic              last_word;

  assign rd_req    = (st == WK_READ);
  assign done      = (st == WK_DONE);
  assign word_fire = rd_req && rd_ack;
  assign last_word = (cnt == CNT_W'(MAX_WORDS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= WK_LOAD;
      rd_addr <= '0;
      cnt     <= '0;
    end else begin
      unique case (st)
        WK_LOAD: begin
          rd_addr <= src_flash ? START_FL : START_EE;
          cnt     <= '0;
          st      <= WK_READ;
        end
        WK_READ: begin
          if (word_fire) begin
            cnt <= cnt + CNT_W'(1);
            if (stop_req || last_word) st <= WK_DONE;
            else rd_addr <= rd_addr + STEP;
          end
        end
        default: st <= WK_DONE;
      endcase
    end
  end

  a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> rd_addr[1:0] == 2'b00);

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (word_fire && !stop_req && !last_word) |=> rd_req && (rd_addr == $past(rd_addr) + STEP));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> rd_req && $stable(rd_addr));

  a_r7_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(MAX_WORDS));

  a_r7_limit_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (word_fire && last_word) |=> done);

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done && !rd_req);

endmodule

// File: rtl/cfgld_parser.sv
module cfgld_parser
  import cfgld_pkg::*;
#(
  parameter logic [15:0] STA_OFS = 16'h0140
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        word_fire,
  input  logic [31:0] rd_data,
  input  logic        rd_err,
  output logic        stop_req,
  output logic [31:0] lo_word,
  output logic [31:0] hi_word
);

  localparam logic [15:0] STA_HI_OFS = STA_OFS + 16'd4;

  logic        want_tag;
  logic [15:0] target;
  logic        take;
  logic        lo_load;
  logic        hi_load;

  assign stop_req = word_fire && (rd_err || (want_tag && !is_tag(rd_data)));
  assign take     = word_fire && !stop_req;
  assign lo_load  = take && !want_tag && (target == STA_OFS);
  assign hi_load  = take && !want_tag && (target == STA_HI_OFS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want_tag <= 1'b1;
      target   <= '0;
      lo_word  <= '0;
      hi_word  <= '0;
    end else if (take) begin
      if (want_tag) begin
        target   <= tag_target(rd_data);
        want_tag <= 1'b0;
      end else begin
        if (lo_load) lo_word <= rd_data;
        if (hi_load) hi_word <= rd_data;
        want_tag <= 1'b1;
      end
    end
  end

  a_r3_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (want_tag != $past(want_tag)));

  a_r4_lo_capture: assert property (@(posedge clk) disable iff (!rst_n)
    lo_load |=> lo_word == $past(rd_data));

  a_r4_hi_capture: assert property (@(posedge clk) disable iff (!rst_n)
    hi_load |=> hi_word == $past(rd_data));

  a_r6_err_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    (word_fire && rd_err) |=> $stable(lo_word) && $stable(hi_word));

endmodule

// File: rtl/cfgld_station.sv
module cfgld_station
  import cfgld_pkg::*;
(
  input  logic [31:0] lo_word,
  input  logic [31:0] hi_word,
  input  logic        done,
  output logic [47:0] station_addr,
  output logic        addr_valid
);

  always_comb begin
    station_addr = pack_station(lo_word, hi_word);
    addr_valid   = done && unicast_ok(station_addr);
  end

endmodule

// File: rtl/cfgld_autoloader.sv
module cfgld_autoloader
  import cfgld_pkg::*;
#(
  parameter int          ADDR_W    = 20,
  parameter logic [31:0] BASE_EE   = 32'h0000_0100,
  parameter logic [31:0] BASE_FL   = 32'h0001_F000,
  parameter int          MAX_WORDS = 64,
  parameter logic [15:0] STA_OFS   = 16'h0140
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_flash,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [31:0]       rd_data,
  input  logic              rd_err,
  output logic [47:0]       station_addr,
  output logic              done,
  output logic              addr_valid
);

  logic        word_fire;
  logic        stop_req;
  logic [31:0] lo_word;
  logic [31:0] hi_word;

  cfgld_walker #(
    .ADDR_W(ADDR_W), .BASE_EE(BASE_EE), .BASE_FL(BASE_FL), .MAX_WORDS(MAX_WORDS)
  ) u_walker (
    .clk(clk), .rst_n(rst_n), .src_flash(src_flash), .rd_ack(rd_ack),
    .stop_req(stop_req), .rd_req(rd_req), .rd_addr(rd_addr),
    .word_fire(word_fire), .done(done)
  );

  cfgld_parser #(.STA_OFS(STA_OFS)) u_parser (
    .clk(clk), .rst_n(rst_n), .word_fire(word_fire), .rd_data(rd_data),
    .rd_err(rd_err), .stop_req(stop_req), .lo_word(lo_word), .hi_word(hi_word)
  );

  cfgld_station u_station (
    .lo_word(lo_word), .hi_word(hi_word), .done(done),
    .station_addr(station_addr), .addr_valid(addr_valid)
  );

  a_r5_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> done && !rd_req);

  a_r9_valid_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> done && (station_addr != 48'd0));

  a_r9_group_bit: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> !station_addr[40]);

  a_r1_idle_before_done: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !addr_valid);

endmodule

// File: tb/tb_cfgld_autoloader.sv
module tb_cfgld_autoloader;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int MAXW = 64;
  localparam int MEMN = 80;
  localparam logic [15:0] STA = 16'h0140;
  localparam int BASE_E = 'h100;
  localparam int BASE_F = 'h1F000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic src_flash = 1'b0;
  logic rd_req;
  logic [AW-1:0] rd_addr;
  logic rd_ack;
  logic [31:0] rd_data;
  logic rd_err;
  logic [47:0] station_addr;
  logic done;
  logic addr_valid;

  int errors = 0;
  int checks = 0;
  logic [31:0] mem [MEMN];
  int err_at = -1;
  int lat = 0;
  int nreads = 0;
  int late_reqs = 0;
  int cur_base = BASE_E;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgld_autoloader dut (
    .clk(clk), .rst_n(rst_n), .src_flash(src_flash), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data), .rd_err(rd_err),
    .station_addr(station_addr), .done(done), .addr_valid(addr_valid)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] tagw(input logic [15:0] ofs);
    return {ofs, 8'hC3, 8'h5A};
  endfunction

  // memory model: answers at falling edges only
  initial begin
    int wcnt = 0;
    rd_ack = 1'b0; rd_data = '0; rd_err = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        rd_ack = 1'b0; rd_err = 1'b0; wcnt = 0;
      end else if (rd_ack) begin
        rd_ack = 1'b0; rd_err = 1'b0; wcnt = 0;
      end else if (rd_req) begin
        if (wcnt >= lat) begin
          if (nreads == 0) chk("R1 first read address", 64'(rd_addr), 64'(cur_base));
          else chk("R2 read address step", 64'(rd_addr), 64'(cur_base + 4 * nreads));
          rd_data = (nreads < MEMN) ? mem[nreads] : 32'h0;
          rd_err  = (nreads == err_at);
          rd_ack  = 1'b1;
          nreads++;
        end else wcnt++;
      end
      if (rst_n && done && rd_req) late_reqs++;
    end
  end

  task automatic clear_mem();
    for (int i = 0; i < MEMN; i++) mem[i] = 32'h0;
    err_at = -1;
  endtask

  task automatic run(input bit flash, input int l);
    src_flash = flash;
    lat = l;
    cur_base = flash ? BASE_F : BASE_E;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    nreads = 0;
    late_reqs = 0;
    chk("R1 done in reset", 64'(done), 64'd0);
    chk("R1 valid in reset", 64'(addr_valid), 64'd0);
    chk("R1 station in reset", 64'(station_addr), 64'd0);
    chk("R1 no request in reset", 64'(rd_req), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done after reset", 64'(done), 64'd0);
    begin
      int guard = 0;
      while (!done && guard < 1000) begin
        @(negedge clk);
        guard++;
      end
      chk("R7 walk terminates", 64'(done), 64'd1);
    end
    repeat (8) @(negedge clk);
    chk("R10 done stays high", 64'(done), 64'd1);
    chk("R10 no request after done", 64'(late_reqs), 64'd0);
  endtask

  task automatic expect_result(input string tag, input int reads,
                               input logic [31:0] lo, input logic [31:0] hi);
    logic [63:0] exp_sta;
    logic [63:0] exp_ok;
    exp_sta = ((64'(hi) & 64'hFFFF) << 32) | 64'(lo);
    exp_ok  = 64'((exp_sta != 0) && (((exp_sta >> 40) & 64'd1) == 0));
    chk({tag, " read count"}, 64'(nreads), 64'(reads));
    chk({"R8 ", tag, " station"}, 64'(station_addr), exp_sta);
    chk({"R9 ", tag, " valid"}, 64'(addr_valid), exp_ok);
  endtask

  initial begin
    // R3 R4 R5: plain image, terminator at word 4
    clear_mem();
    mem[0] = tagw(STA);        mem[1] = 32'h6AF6_00DC;
    mem[2] = tagw(STA + 4);    mem[3] = 32'hBEEF_000B;
    run(1'b0, 0);
    expect_result("R5 basic", 5, 32'h6AF6_00DC, 32'h0000_000B);

    // R4 foreign target dropped, high before low, flash base, stop on 0x5B
    clear_mem();
    mem[0] = tagw(16'h0200);   mem[1] = 32'h1234_5678;
    mem[2] = tagw(STA + 4);    mem[3] = 32'h0000_0002;
    mem[4] = tagw(STA);        mem[5] = 32'h3344_5566;
    mem[6] = 32'h0000_005B;
    run(1'b1, 2);
    expect_result("R4 foreign", 7, 32'h3344_5566, 32'h0000_0002);

    // R3 value words ending in 0x5A; R4 overwrite; R9 group bit set
    clear_mem();
    mem[0] = tagw(STA);        mem[1] = 32'h1111_115A;
    mem[2] = tagw(STA);        mem[3] = 32'h2222_225A;
    mem[4] = tagw(STA + 4);    mem[5] = 32'h0000_0100;
    run(1'b0, 1);
    expect_result("R3 overwrite", 7, 32'h2222_225A, 32'h0000_0100);

    // R5 immediate terminator
    clear_mem();
    run(1'b1, 3);
    expect_result("R5 empty", 1, 32'h0, 32'h0);

    // R6 error on a value word
    clear_mem();
    mem[0] = tagw(STA);        mem[1] = 32'hAAAA_AAAA;
    err_at = 1;
    run(1'b0, 0);
    expect_result("R6 value err", 2, 32'h0, 32'h0);

    // R6 error on a tag-shaped word
    clear_mem();
    mem[0] = tagw(STA);        mem[1] = 32'h5555_5555;
    err_at = 0;
    run(1'b1, 1);
    expect_result("R6 tag err", 1, 32'h0, 32'h0);

    // R7 unterminated image: every word is a tag-shaped word
    clear_mem();
    for (int i = 0; i < MEMN; i++) mem[i] = tagw(16'h7777);
    mem[0] = tagw(STA);        mem[1] = 32'h0102_0304;
    mem[2] = tagw(STA + 4);    mem[3] = 32'h0000_0A0B;
    run(1'b0, 0);
    expect_result("R7 limit", MAXW, 32'h0102_0304, 32'h0000_0A0B);

    // R8 R9 sweep of every single address bit, noise in ignored high bits
    for (int k = 0; k < 48; k++) begin
      logic [63:0] a;
      a = 64'd1 << k;
      clear_mem();
      mem[0] = tagw(STA);      mem[1] = a[31:0];
      mem[2] = tagw(STA + 4);  mem[3] = {16'hABCD, a[47:32]};
      run(k[0], k % 4);
      expect_result("R8 sweep", 5, a[31:0], {16'hABCD, a[47:32]});
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule